// File: doc/BRIEF.md
# Double-Data-Rate Read Strobe Capture

This block sits on the controller side of a double-data-rate graphics memory read path. The memory returns a data strobe together with the data bus. After the strobe has been delayed by a quarter cycle, each rising strobe edge latches the data bus into an even register and each falling edge latches it into an odd register. The two halves of each beat pair then move into the internal clock domain as one word of twice the bus width. Each burst of four beats yields two words, in burst order.

The block tracks issued reads and opens a strobe-capture window at a fixed offset after each read command. The offset is set by the CAS latency (2 or 3) and an extra round-trip delay. The window opens during the strobe preamble and closes after the postamble, so a parked or floating strobe never writes the capture registers. The internal-clock stage forwards data only in the two clock cycles that carry real beats, so anything the strobe registers pick up earlier in the window is overwritten and never seen. A strobe edge that arrives while the window is closed sets a sticky error flag.

The window controller is a four-state machine. ST_IDLE moves to ST_PRE when a read's preamble slot comes due. ST_PRE always moves to ST_BEAT_A. ST_BEAT_A always moves to ST_BEAT_B. ST_BEAT_B moves to ST_BEAT_A when a following read's first-beat slot is due (a gapless burst), to ST_PRE when only its preamble slot is due, and to ST_IDLE otherwise. The window is open in every state except ST_IDLE.

Top module: `ddr_rd_capture`

## Requirements
- R1: While reset is asserted and just after it is released, rd_valid is 0, rd_data is 0 and strobe_err is 0.
- R2: Take a read sampled on clock edge k, with latency L = 2 + rt_delay when cas_lat3 = 0, or L = 3 + rt_delay when cas_lat3 = 1. The capture window is open in the clock cycles following edges k+L-1, k+L and k+L+1. rd_valid is high in the cycles following edges k+L+1 and k+L+2.
- R3: A word packs the beat latched on the rising strobe edge into bits [DQ_W-1:0] and the beat latched on the following falling edge into bits [2*DQ_W-1:DQ_W]. The first word is {beat1, beat0} and the second is {beat3, beat2}.
- R4: An isolated burst of four beats produces exactly two rd_valid cycles, back to back and in burst order. rd_data holds its last value while rd_valid is low.
- R5: Reads issued two clock edges apart give gapless bursts. The window stays open across both bursts, four consecutive valid words come out in order, and no error is flagged.
- R6: Reads issued three edges apart re-enter the preamble state between the bursts and deliver both bursts correctly.
- R7: A strobe pulse while the window is closed sets strobe_err by the second clock edge after the pulse. strobe_err stays set until reset, and the pulse changes neither rd_data nor rd_valid.
- R8: Strobe edges during the preamble cycle (window open, before the first beat) are not forwarded. They produce no extra rd_valid, leave the burst words intact and do not set strobe_err.
- R9: Both CAS latency settings and every rt_delay value from 0 to its maximum place the words at the cycles given in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dqs | input | 1 | Returned data strobe, already delayed by a quarter cycle |
| dq | input | DQ_W | External read data bus |
| rd_issue | input | 1 | One-cycle pulse when a burst-of-four read command is issued |
| cas_lat3 | input | 1 | 0 selects CAS latency 2, 1 selects CAS latency 3 |
| rt_delay | input | RT_W | Extra round-trip delay in whole clock cycles |
| rd_data | output | 2*DQ_W | Captured word, {odd beat, even beat} |
| rd_valid | output | 1 | High for one cycle per delivered word |
| strobe_err | output | 1 | Sticky flag for a strobe edge outside the window |

## Verification
The bench builds the block with DQ_W = 8 and RT_W = 2. This gives total latencies from 2 to 6 cycles, so both the shortest history tap and the deepest one are exercised. The bench drives reads at both CAS settings with round-trip delays of 0, 1, 2 and 3, using isolated, gapless and one-gap spacings. It injects strobe pulses both in the preamble and outside any window. A behavioural model holding expected words per cycle is compared with rd_valid, rd_data and strobe_err on every clock.

// File: rtl/rdcap_pkg.sv
package rdcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRE    = 2'd1,
        ST_BEAT_A = 2'd2,
        ST_BEAT_B = 2'd3
    } win_state_t;

    localparam int unsigned CL_SHORT = 2;
    localparam int unsigned CL_LONG  = 3;

endpackage

// File: rtl/rdcap_issue_track.sv
module rdcap_issue_track #(
    parameter int RT_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_issue,
    input  logic            cas_lat3,
    input  logic [RT_W-1:0] rt_delay,
    output logic            pre_hit,
    output logic            start_hit,
    output logic            pend_any
);
    import rdcap_pkg::*;

    localparam int MAX_LAT = int'(CL_LONG) + (1 << RT_W) - 1;
    localparam int DEPTH   = MAX_LAT + 2;
    localparam int LAT_W   = $clog2(MAX_LAT + 1);

    // hist[m] is set in the cycle after edge k+m for a read sampled at edge k
    logic [DEPTH-1:0] hist;
    logic [LAT_W-1:0] lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
        end else begin
            hist <= {hist[DEPTH-2:0], rd_issue};
        end
    end

    always_comb begin
        lat = (cas_lat3 ? LAT_W'(CL_LONG) : LAT_W'(CL_SHORT)) + LAT_W'(rt_delay);
    end

    // Preamble slot is due at edge k+L-1, first beat slot at edge k+L
    always_comb begin
        pre_hit   = 1'b0;
        start_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i + 2 == int'(lat)) pre_hit   = hist[i];
            if (i + 1 == int'(lat)) start_hit = hist[i];
        end
    end

    assign pend_any = |hist;

endmodule

// File: rtl/rdcap_window_fsm.sv
module rdcap_window_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic pre_hit,
    input  logic start_hit,
    output logic win_open,
    output logic beat
);
    import rdcap_pkg::*;

    win_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (pre_hit) state_nx = ST_PRE;
            ST_PRE:    state_nx = ST_BEAT_A;
            ST_BEAT_A: state_nx = ST_BEAT_B;
            ST_BEAT_B: begin
                if (start_hit)    state_nx = ST_BEAT_A;
                else if (pre_hit) state_nx = ST_PRE;
                else              state_nx = ST_IDLE;
            end
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        win_open = (state != ST_IDLE);
        beat     = (state == ST_BEAT_A) || (state == ST_BEAT_B);
    end

    AST_PRE_TO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE) |=> (state == ST_BEAT_A)); // R2

    AST_BEAT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BEAT_A) |=> (state == ST_BEAT_B)); // R4

endmodule

// File: rtl/rdcap_strobe_capture.sv
module rdcap_strobe_capture #(
    parameter int DQ_W = 8
) (
    input  logic            dqs,
    input  logic            rst_n,
    input  logic [DQ_W-1:0] dq,
    input  logic            win_open,
    output logic [DQ_W-1:0] even_q,
    output logic [DQ_W-1:0] odd_q,
    output logic            err_edge
);
    logic err_rise, err_fall;

    always_ff @(posedge dqs or negedge rst_n) begin
        if (!rst_n) begin
            even_q   <= '0;
            err_rise <= 1'b0;
        end else if (win_open) begin
            even_q   <= dq;
        end else begin
            err_rise <= 1'b1;
        end
    end

    always_ff @(negedge dqs or negedge rst_n) begin
        if (!rst_n) begin
            odd_q    <= '0;
            err_fall <= 1'b0;
        end else if (win_open) begin
            odd_q    <= dq;
        end else begin
            err_fall <= 1'b1;
        end
    end

    assign err_edge = err_rise | err_fall;

endmodule

// File: rtl/rdcap_word_stage.sv
module rdcap_word_stage #(
    parameter int DQ_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat,
    input  logic [DQ_W-1:0]   even_q,
    input  logic [DQ_W-1:0]   odd_q,
    input  logic              err_edge,
    output logic [2*DQ_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              strobe_err
);
    logic err_meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= beat;
            if (beat) rd_data <= {odd_q, even_q};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_meta   <= 1'b0;
            strobe_err <= 1'b0;
        end else begin
            err_meta   <= err_edge;
            strobe_err <= err_meta;
        end
    end

    AST_VALID_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |=> rd_valid); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_err |=> strobe_err); // R7

endmodule

// File: rtl/ddr_rd_capture.sv
module ddr_rd_capture #(
    parameter int DQ_W = 8,
    parameter int RT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dqs,
    input  logic [DQ_W-1:0]   dq,
    input  logic              rd_issue,
    input  logic              cas_lat3,
    input  logic [RT_W-1:0]   rt_delay,
    output logic [2*DQ_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              strobe_err
);
    logic            pre_hit, start_hit, pend_any;
    logic            win_open, beat;
    logic [DQ_W-1:0] even_q, odd_q;
    logic            err_edge;

    rdcap_issue_track #(.RT_W(RT_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_issue  (rd_issue),
        .cas_lat3  (cas_lat3),
        .rt_delay  (rt_delay),
        .pre_hit   (pre_hit),
        .start_hit (start_hit),
        .pend_any  (pend_any)
    );

    rdcap_window_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_hit   (pre_hit),
        .start_hit (start_hit),
        .win_open  (win_open),
        .beat      (beat)
    );

    rdcap_strobe_capture #(.DQ_W(DQ_W)) u_cap (
        .dqs      (dqs),
        .rst_n    (rst_n),
        .dq       (dq),
        .win_open (win_open),
        .even_q   (even_q),
        .odd_q    (odd_q),
        .err_edge (err_edge)
    );

    rdcap_word_stage #(.DQ_W(DQ_W)) u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat       (beat),
        .even_q     (even_q),
        .odd_q      (odd_q),
        .err_edge   (err_edge),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .strobe_err (strobe_err)
    );

    AST_WIN_HAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |-> pend_any); // R2

    AST_VALID_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(win_open)); // R8

endmodule

// File: tb/ddr_rd_capture_bench.sv
module ddr_rd_capture_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DQ_W  = 8;
    localparam int RT_W  = 2;
    localparam int SLOTS = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dqs = 1'b0;
    logic [DQ_W-1:0]   dq = '0;
    logic              rd_issue = 1'b0;
    logic              cas_lat3 = 1'b0;
    logic [RT_W-1:0]   rt_delay = '0;
    logic [2*DQ_W-1:0] rd_data;
    logic              rd_valid;
    logic              strobe_err;

    ddr_rd_capture #(.DQ_W(DQ_W), .RT_W(RT_W)) u_ddr_rd_capture (
        .clk(clk), .rst_n(rst_n), .dqs(dqs), .dq(dq), .rd_issue(rd_issue),
        .cas_lat3(cas_lat3), .rt_delay(rt_delay), .rd_data(rd_data),
        .rd_valid(rd_valid), .strobe_err(strobe_err)
    );

    // behavioural schedule, indexed by clock-edge number
    bit              beat_en [SLOTS];
    logic [DQ_W-1:0] beat_e  [SLOTS];
    logic [DQ_W-1:0] beat_o  [SLOTS];
    bit              stray   [SLOTS];
    bit              win_exp [SLOTS];
    bit              exp_v   [SLOTS];
    logic [2*DQ_W-1:0] exp_w [SLOTS];

    int    edge_cnt = 0;
    int    err_due  = -1;
    int    checks   = 0;
    int    errors   = 0;
    string cur_req  = "R1";
    logic [2*DQ_W-1:0] last_w = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at edge %0d: actual %h expected %h",
                     req, what, edge_cnt, act, exp);
        end
    endtask

    // strobe and data driver: quarter-cycle shifted strobe
    initial begin
        forever begin
            @(posedge clk);
            edge_cnt++;
            if (edge_cnt < SLOTS) begin
                if (beat_en[edge_cnt]) begin
                    #2 dq = beat_e[edge_cnt];
                    #1 dqs = 1'b1;
                    #3 dq = beat_o[edge_cnt];
                    #2 dqs = 1'b0;
                end else if (stray[edge_cnt]) begin
                    #2 dq = DQ_W'(edge_cnt) ^ 8'hA5;
                    #1 dqs = 1'b1;
                    #3 dq = ~dq;
                    #2 dqs = 1'b0;
                    if (!win_exp[edge_cnt - 0] && err_due < 0) err_due = edge_cnt + 2;
                end
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && edge_cnt < SLOTS) begin
            if (exp_v[edge_cnt]) last_w = exp_w[edge_cnt];
            check(rd_valid == exp_v[edge_cnt], cur_req, "rd_valid",
                  32'(rd_valid), 32'(exp_v[edge_cnt]));
            check(rd_data == last_w, cur_req, "rd_data", 32'(rd_data), 32'(last_w));
            check(strobe_err == (err_due >= 0 && edge_cnt >= err_due), "R7",
                  "strobe_err", 32'(strobe_err), 32'(err_due >= 0 && edge_cnt >= err_due));
        end
    end

    task automatic issue(input bit cl3, input int rt,
                         input logic [DQ_W-1:0] b0, input logic [DQ_W-1:0] b1,
                         input logic [DQ_W-1:0] b2, input logic [DQ_W-1:0] b3,
                         output int e, output int lat);
        @(negedge clk);
        cas_lat3 = cl3;
        rt_delay = RT_W'(rt);
        rd_issue = 1'b1;
        e   = edge_cnt + 1;
        lat = (cl3 ? 3 : 2) + rt;
        beat_en[e+lat]   = 1'b1; beat_e[e+lat]   = b0; beat_o[e+lat]   = b1;
        beat_en[e+lat+1] = 1'b1; beat_e[e+lat+1] = b2; beat_o[e+lat+1] = b3;
        win_exp[e+lat-1] = 1'b1; win_exp[e+lat] = 1'b1; win_exp[e+lat+1] = 1'b1;
        exp_v[e+lat+1] = 1'b1; exp_w[e+lat+1] = {b1, b0};
        exp_v[e+lat+2] = 1'b1; exp_w[e+lat+2] = {b3, b2};
        @(negedge clk);
        rd_issue = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual hung expected done");
        finish_run();
    end

    initial begin
        int e, lat, e2, lat2;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(rd_valid == 1'b0, "R1", "rd_valid in reset", 32'(rd_valid), 0);
        check(rd_data == '0, "R1", "rd_data in reset", 32'(rd_data), 0);
        check(strobe_err == 1'b0, "R1", "strobe_err in reset", 32'(strobe_err), 0);
        rst_n = 1'b1;
        idle(2);

        // R2 R3 R4: isolated burst, CL2, no extra delay
        cur_req = "R2 R3 R4";
        issue(1'b0, 0, 8'h11, 8'h22, 8'h33, 8'h44, e, lat);
        idle(8);

        // R9: CL3 with two cycles of round trip, then CL2 with one
        cur_req = "R9";
        issue(1'b1, 2, 8'hC1, 8'hC2, 8'hC3, 8'hC4, e, lat);
        idle(10);
        issue(1'b0, 1, 8'h5A, 8'hA5, 8'h0F, 8'hF0, e, lat);
        idle(8);

        // R5: gapless pair, CL2 rt1
        cur_req = "R5";
        issue(1'b0, 1, 8'h01, 8'h02, 8'h03, 8'h04, e, lat);
        issue(1'b0, 1, 8'h05, 8'h06, 8'h07, 8'h08, e2, lat2);
        check(e2 - e == 2, "R5", "issue spacing", 32'(e2 - e), 2);
        idle(10);

        // R6: one idle cycle between reads, CL3 rt0
        cur_req = "R6";
        issue(1'b1, 0, 8'h9A, 8'h9B, 8'h9C, 8'h9D, e, lat);
        idle(1);
        issue(1'b1, 0, 8'hE1, 8'hE2, 8'hE3, 8'hE4, e2, lat2);
        check(e2 - e == 3, "R6", "issue spacing", 32'(e2 - e), 3);
        idle(10);

        // R8: glitch pulse during the preamble cycle
        cur_req = "R8";
        issue(1'b0, 2, 8'h6B, 8'h7C, 8'h8D, 8'h9E, e, lat);
        stray[e + lat - 1] = 1'b1;
        idle(10);
        check(strobe_err == 1'b0, "R8", "no error from preamble glitch", 32'(strobe_err), 0);
        check(rd_data == 16'h9E8D, "R8", "last word intact", 32'(rd_data), 32'h9E8D);

        // R9 + R5: deepest latency, gapless
        cur_req = "R9 R5";
        issue(1'b1, 3, 8'hD0, 8'hD1, 8'hD2, 8'hD3, e, lat);
        issue(1'b1, 3, 8'hD4, 8'hD5, 8'hD6, 8'hD7, e2, lat2);
        idle(14);
        check(rd_data == 16'hD7D6, "R9", "final word of deep gapless pair", 32'(rd_data), 32'hD7D6);

        // R7: stray pulse while closed
        cur_req = "R7";
        stray[edge_cnt + 1] = 1'b1;
        idle(5);
        check(strobe_err == 1'b1, "R7", "sticky error set", 32'(strobe_err), 1);
        check(rd_data == 16'hD7D6, "R7", "data untouched by stray", 32'(rd_data), 32'hD7D6);
        issue(1'b0, 0, 8'h3C, 8'h4D, 8'h5E, 8'h6F, e, lat);
        idle(8);
        check(strobe_err == 1'b1, "R7", "error still set", 32'(strobe_err), 1);

        idle(4);
        finish_run();
    end

endmodule